// File: doc/BRIEF.md
# Converter Parallel Host Interface

This block is the digital host-side front end of a multichannel sampling converter. A host reaches it through a 13-line parallel data bus with active-low chip select, write and read strobes. It stores a configuration word that selects the input channel, the bus width, the role of the SYNC pin and a standby request. It delivers conversion results back over the same bus. The analog path is replaced by a timer stub. The stub runs a fixed number of clocks per conversion and then produces a result word whose contents can be predicted.

All strobes and the SYNC input are asynchronous to the block clock. Each passes through a two-flop synchronizer before its edges are detected. A strap input is sampled while reset is held and fixes which WR edge commits a write. The data and SYNC pins are presented as split input, output and output-enable vectors, so that pad cells outside the block can form the bidirectional lines. In 8-bit mode the 13-bit result is read as two bytes: the low byte first, then the high byte.

Top module: `conv_host_if`

## Requirements
- R1: While reset is held and in the first cycles after it, `mux_sel` is 0, `sync_oe` is 1, `sync_o` is 0, `rdy_n` is 1, `stdby_n` is 1 and `data_oe` is all zeros.
- R2: `wmode_i` is captured during reset and ignored after it. With the captured value 0, a write commits after WR rises. With the captured value 1, a write commits after WR falls, while WR is still low.
- R3: A WR strobe has no effect on the configuration unless `cs_n` is low.
- R4: `data_oe` is nonzero only while `cs_n` and `rd_n` are both low.
- R5: Configuration bit 12 selects the bus width. When it is 0, a read drives `data_oe` = 0x0FF. When it is 1, a read drives `data_oe` = 0x1FFF.
- R6: `mux_sel` equals configuration bits 3:0 of the last committed write.
- R7: Configuration bit 8 sets the SYNC role. With bit 8 = 1, `sync_oe` is 0 and a rising edge on `sync_i` starts a conversion. With bit 8 = 0, `sync_oe` is 1 and `sync_o` is high for exactly CONV_CYCLES (default 44) clocks per conversion.
- R8: A committed write with bit 11 set starts a conversion. The bit is not kept in the configuration.
- R9: Each completed conversion yields the result {mux_sel[3:0], n[8:0]}, where n is the count of completed conversions since reset (1 for the first). A full-width read returns this result on data_o[12:0], with bit 12 as the MSB.
- R10: In 8-bit mode, the first read under one CS assertion returns result[7:0] on data_o[7:0]. The second read returns result[12:8] on data_o[4:0], with data_o[7:5] = 0. Deasserting CS returns the next read to the low byte.
- R11: `rdy_n` goes high when a conversion starts, stays high while it runs, and goes low when it completes.
- R12: A start request (a SYNC edge or a start write) that arrives while a conversion runs is ignored. The running conversion keeps its length, and only one result count is added.
- R13: Configuration bit 9 requests standby. While it is set, `stdby_n` is 0 and start requests are ignored. Clearing it sets `stdby_n` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wmode_i | input | 1 | Write-edge strap, captured during reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| wr_n | input | 1 | Asynchronous active-low write strobe |
| rd_n | input | 1 | Asynchronous active-low read strobe |
| data_i | input | 13 | Data lines as seen from the pads |
| data_o | output | 13 | Read data toward the pads |
| data_oe | output | 13 | Per-line output enable for the data pads |
| sync_i | input | 1 | SYNC pad input (conversion trigger) |
| sync_o | output | 1 | Busy indication toward the SYNC pad |
| sync_oe | output | 1 | SYNC pad output enable |
| rdy_n | output | 1 | Active-low result-ready indication |
| stdby_n | output | 1 | Active-low standby status |
| mux_sel | output | 4 | Channel select for the input multiplexer |

## Verification
The hardest state to reach is a start request that lands in the middle of a running conversion. The request has to arrive after the synchronizer delay but well before the CONV_CYCLES window closes. To get there, the bench forks a busy-length monitor against the stimulus. It starts a conversion with a SYNC edge, then fires a second SYNC edge and a start write a few cycles later. It then checks that the busy window still spans exactly CONV_CYCLES clocks and that the result counter moved by one. The two write-edge strap settings each need their own reset, so the bench resets a second time with the strap high to confirm that the configuration changes while WR is still held low.

// File: rtl/conv_host_pkg.sv
// Shared widths, configuration bit positions and the committed-configuration
// record for the converter host interface.
package conv_host_pkg;
    localparam int DW       = 13;        // data bus lines
    localparam int LOW_W    = 8;         // active lines in narrow mode
    localparam int CHW      = 4;         // channel select width
    localparam int SEQ_W    = DW - CHW;  // result sequence field width

    localparam int CFG_BW      = 12;
    localparam int CFG_START   = 11;
    localparam int CFG_STBY    = 9;
    localparam int CFG_SYNC_IN = 8;

    typedef struct packed {
        logic           bw;       // 1: full-width bus
        logic           start;    // one-shot conversion request
        logic           stby;     // standby request
        logic           sync_in;  // 1: SYNC is a trigger input
        logic [CHW-1:0] ch;       // channel select
    } cfg_t;
endpackage

// File: rtl/conv_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous inputs.
// Assumes each bit is a level that stays stable for several clocks.
module conv_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages per bit toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/conv_cfg_port.sv
// Write side: captures pad data while CS and WR are both low, and commits it
// on the WR edge chosen by the strap captured during reset. Assumes cs_s and
// wr_s/wr_p are the synchronized and delayed strobe levels.
module conv_cfg_port
    import conv_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wmode_i,
    input  logic cs_raw_n,
    input  logic wr_raw_n,
    input  cfg_t wr_fields_i,
    input  logic cs_s,
    input  logic wr_s,
    input  logic wr_p,
    output cfg_t cfg_o,
    output logic start_wr_o,
    output logic wmode_o
);
    logic wmode_q;
    cfg_t hold_q;
    cfg_t cfg_q;
    logic commit;

    // Strap capture: follows the pin only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) wmode_q <= wmode_i;
    end

    // Input buffer: tracks the pads only while CS and WR are both low
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold_q <= '0;
        else if (!cs_raw_n && !wr_raw_n)  hold_q <= wr_fields_i;
    end

    // Commit on the selected synchronized WR edge with CS low
    always_comb begin
        if (wmode_q) commit = !cs_s && wr_p && !wr_s;
        else         commit = !cs_s && !wr_p && wr_s;
    end

    // Configuration register; the start request is not retained
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (commit) begin
            cfg_q       <= hold_q;
            cfg_q.start <= 1'b0;
        end
    end

    assign cfg_o      = cfg_q;
    assign start_wr_o = commit && hold_q.start;
    assign wmode_o    = wmode_q;
endmodule

// File: rtl/conv_timer.sv
// Conversion stub: on an accepted start it stays busy for CONV_CYCLES clocks,
// then publishes {channel, completed-count}. Starts during busy are dropped.
// Assumes CONV_CYCLES >= 2.
module conv_timer #(
    parameter int CONV_CYCLES = 44,
    parameter int CHW         = 4,
    parameter int SEQ_W       = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [CHW-1:0]       ch_i,
    output logic                 busy_o,
    output logic                 rdy_n_o,
    output logic [CHW+SEQ_W-1:0] result_o
);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CONV_CYCLES - 1);

    logic                 busy_q;
    logic                 rdy_n_q;
    logic [CW-1:0]        cnt_q;
    logic [SEQ_W-1:0]     seq_q;
    logic [CHW+SEQ_W-1:0] res_q;
    logic                 done;

    assign done = busy_q && (cnt_q == LAST);

    // Busy window, cycle counter and ready flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rdy_n_q <= 1'b1;
            cnt_q   <= '0;
        end else if (!busy_q && start_i) begin
            busy_q  <= 1'b1;
            rdy_n_q <= 1'b1;
            cnt_q   <= '0;
        end else if (done) begin
            busy_q  <= 1'b0;
            rdy_n_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Result publication at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
            res_q <= '0;
        end else if (done) begin
            seq_q <= seq_q + 1'b1;
            res_q <= {ch_i, seq_q + 1'b1};
        end
    end

    assign busy_o   = busy_q;
    assign rdy_n_o  = rdy_n_q;
    assign result_o = res_q;
endmodule

// File: rtl/conv_read_port.sv
// Read side: enables the pad drivers from the raw CS/RD levels and selects
// the full result or one byte of it. The byte pointer advances at the end of
// each narrow read and clears when synchronized CS goes high.
module conv_read_port #(
    parameter int DW    = 13,
    parameter int LOW_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_raw_n,
    input  logic          rd_raw_n,
    input  logic          cs_s,
    input  logic          rd_s,
    input  logic          rd_p,
    input  logic          bw_i,
    input  logic [DW-1:0] result_i,
    output logic [DW-1:0] data_o,
    output logic [DW-1:0] data_oe
);
    localparam int HI_W = DW - LOW_W;
    localparam logic [DW-1:0] LOW_MASK = {{HI_W{1'b0}}, {LOW_W{1'b1}}};

    logic ptr_q;

    // Byte pointer: high byte after one narrow read, cleared by CS release
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s)                  ptr_q <= 1'b0;
        else if (!bw_i && !rd_p && rd_s)     ptr_q <= !ptr_q;
    end

    // Output data selection
    always_comb begin
        if (bw_i)       data_o = result_i;
        else if (ptr_q) data_o = {{(DW-HI_W){1'b0}}, result_i[DW-1:LOW_W]};
        else            data_o = {{HI_W{1'b0}}, result_i[LOW_W-1:0]};
    end

    // Pad drivers: on only while CS and RD are both low
    always_comb begin
        if (!cs_raw_n && !rd_raw_n) data_oe = bw_i ? {DW{1'b1}} : LOW_MASK;
        else                        data_oe = '0;
    end
endmodule

// File: rtl/conv_host_if.sv
// Top of the converter host interface: synchronizes the bus strobes and the
// SYNC input, commits configuration writes, runs the conversion stub and
// serves result reads. Pads are split into input/output/enable vectors.
module conv_host_if
    import conv_host_pkg::*;
#(
    parameter int CONV_CYCLES = 44
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wmode_i,
    input  logic           cs_n,
    input  logic           wr_n,
    input  logic           rd_n,
    input  logic [DW-1:0]  data_i,
    output logic [DW-1:0]  data_o,
    output logic [DW-1:0]  data_oe,
    input  logic           sync_i,
    output logic           sync_o,
    output logic           sync_oe,
    output logic           rdy_n,
    output logic           stdby_n,
    output logic [CHW-1:0] mux_sel
);
    logic cs_s, wr_s, rd_s, sync_s;
    logic wr_p, rd_p, sync_p;
    logic wmode_q;
    logic start_wr, start_req, busy;
    cfg_t cfg, wr_fields;
    logic [DW-1:0] result;

    conv_sync #(.W(4), .RST_VAL(4'b1110)) sync_i0 (
        .clk(clk), .rst_n(rst_n),
        .async_i({cs_n, wr_n, rd_n, sync_i}),
        .sync_o({cs_s, wr_s, rd_s, sync_s})
    );

    // Delayed copies for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p   <= 1'b1;
            rd_p   <= 1'b1;
            sync_p <= 1'b0;
        end else begin
            wr_p   <= wr_s;
            rd_p   <= rd_s;
            sync_p <= sync_s;
        end
    end

    assign wr_fields = '{bw: data_i[CFG_BW], start: data_i[CFG_START],
                         stby: data_i[CFG_STBY], sync_in: data_i[CFG_SYNC_IN],
                         ch: data_i[CHW-1:0]};

    conv_cfg_port cfg_i (
        .clk(clk), .rst_n(rst_n), .wmode_i(wmode_i),
        .cs_raw_n(cs_n), .wr_raw_n(wr_n), .wr_fields_i(wr_fields),
        .cs_s(cs_s), .wr_s(wr_s), .wr_p(wr_p),
        .cfg_o(cfg), .start_wr_o(start_wr), .wmode_o(wmode_q)
    );

    assign start_req = (start_wr || (cfg.sync_in && sync_s && !sync_p)) && !cfg.stby;

    conv_timer #(.CONV_CYCLES(CONV_CYCLES), .CHW(CHW), .SEQ_W(SEQ_W)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_req), .ch_i(cfg.ch),
        .busy_o(busy), .rdy_n_o(rdy_n), .result_o(result)
    );

    conv_read_port #(.DW(DW), .LOW_W(LOW_W)) rd_i (
        .clk(clk), .rst_n(rst_n), .cs_raw_n(cs_n), .rd_raw_n(rd_n),
        .cs_s(cs_s), .rd_s(rd_s), .rd_p(rd_p), .bw_i(cfg.bw),
        .result_i(result), .data_o(data_o), .data_oe(data_oe)
    );

    assign sync_o  = busy;
    assign sync_oe = !cfg.sync_in;
    assign stdby_n = !cfg.stby;
    assign mux_sel = cfg.ch;
endmodule

// File: rtl/conv_host_chk.sv
// Property checker for conv_host_if, attached through bind below.
module conv_host_chk #(
    parameter int CONV_CYCLES = 44
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        rd_n,
    input logic [12:0] data_oe,
    input logic        sync_o,
    input logic        rdy_n,
    input logic        stdby_n,
    input logic [3:0]  mux_sel,
    input logic        cs_s,
    input logic        wmode_q
);
    int run_cnt;

    // Length of the current busy window
    always_ff @(posedge clk) begin
        if (!rst_n)      run_cnt <= 0;
        else if (sync_o) run_cnt <= run_cnt + 1;
        else             run_cnt <= 0;
    end

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != '0) |-> (!cs_n && !rd_n));

    // R5
    oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe == 13'h0000) || (data_oe == 13'h00FF) || (data_oe == 13'h1FFF));

    // R3
    cfg_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_sel) |-> !$past(cs_s));

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(wmode_q));

    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> rdy_n);

    // R12
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CONV_CYCLES);

    // R13
    stby_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(stdby_n));
endmodule

bind conv_host_if conv_host_chk #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .data_oe(data_oe),
    .sync_o(sync_o), .rdy_n(rdy_n), .stdby_n(stdby_n), .mux_sel(mux_sel),
    .cs_s(cs_s), .wmode_q(wmode_q)
);

// File: tb/conv_host_if_tb_top.sv
module conv_host_if_tb_top;
    localparam int CONV = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wmode_i = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sync_i = 1'b0;
    logic [12:0] data_i = '0;
    logic [12:0] data_o, data_oe;
    logic        sync_o, sync_oe, rdy_n, stdby_n;
    logic [3:0]  mux_sel;

    int n_chk = 0, n_bad = 0, rdy_bad = 0, seq = 0;
    bit done = 0;

    always #4 clk = ~clk;

    conv_host_if #(.CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wmode_i(wmode_i), .cs_n(cs_n), .wr_n(wr_n),
        .rd_n(rd_n), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .sync_i(sync_i), .sync_o(sync_o), .sync_oe(sync_oe), .rdy_n(rdy_n),
        .stdby_n(stdby_n), .mux_sel(mux_sel)
    );

    function automatic logic [12:0] cfgv(input logic [3:0] ch, input logic bw,
                                         input logic sin, input logic stb, input logic st);
        return {bw, st, 1'b0, stb, sin, 4'b0000, ch};
    endfunction

    function automatic logic [12:0] exp_res(input logic [3:0] ch, input int n);
        return {ch, n[8:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [12:0] v);
        data_i = v; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1; data_i = '0;
        repeat (5) @(negedge clk);
    endtask

    task automatic bus_rd(output logic [12:0] d, output logic [12:0] oe);
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (2) @(negedge clk);
        d = data_o; oe = data_oe;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic cs_idle();
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic measure_busy(output int n);
        int t = 0;
        while (sync_o !== 1'b1 && t < 300) begin @(negedge clk); t++; end
        n = 0;
        while (sync_o === 1'b1 && n < 300) begin
            if (rdy_n !== 1'b1) rdy_bad++;
            @(negedge clk); n++;
        end
    endtask

    task automatic wait_ready();
        int t = 0;
        while (rdy_n !== 1'b0 && t < 300) begin @(negedge clk); t++; end
    endtask

    task automatic do_reset(input logic strap);
        wmode_i = strap;
        @(negedge clk); rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [12:0] d, oe, r;
        int n;
        void'($urandom(32'd2024));
        do_reset(1'b0);

        // R1 reset state
        check("R1 mux_sel", mux_sel, 0);
        check("R1 sync_oe", sync_oe, 1);
        check("R1 sync_o", sync_o, 0);
        check("R1 rdy_n", rdy_n, 1);
        check("R1 stdby_n", stdby_n, 1);
        check("R1 data_oe", data_oe, 0);

        // R3 write strobe without chip select
        data_i = cfgv(4'd5, 1, 0, 0, 0); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1; repeat (6) @(negedge clk);
        check("R3 no-CS write ignored", mux_sel, 0);

        // R2 rising-edge mode: no commit while WR held low
        data_i = cfgv(4'd3, 1, 0, 0, 0); cs_n = 1'b0; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R2 rising mode held low", mux_sel, 0);
        wr_n = 1'b1; repeat (5) @(negedge clk);
        check("R2 R6 rising mode commit", mux_sel, 3);
        cs_n = 1'b1; repeat (5) @(negedge clk);

        // R2 strap change after reset ignored
        wmode_i = 1'b1;
        data_i = cfgv(4'd6, 1, 0, 0, 0); cs_n = 1'b0; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R2 strap change ignored", mux_sel, 3);
        wr_n = 1'b1; repeat (5) @(negedge clk);
        check("R6 channel 6", mux_sel, 6);
        cs_n = 1'b1; repeat (5) @(negedge clk);

        // R4 chip select alone does not drive
        cs_n = 1'b0; repeat (2) @(negedge clk);
        check("R4 CS without RD", data_oe, 0);
        cs_n = 1'b1; rd_n = 1'b0; repeat (2) @(negedge clk);
        check("R4 RD without CS", data_oe, 0);
        rd_n = 1'b1; repeat (3) @(negedge clk);

        // R8 R7 R11 write-started conversion in SYNC output mode
        rdy_bad = 0;
        fork
            measure_busy(n);
            bus_wr(cfgv(4'd6, 1, 0, 0, 1));
        join
        seq++;
        check("R7 busy length on sync_o", n, CONV);
        check("R11 rdy_n high during busy", rdy_bad, 0);
        @(negedge clk);
        check("R11 rdy_n low after completion", rdy_n, 0);
        bus_rd(d, oe); cs_idle();
        check("R5 full-width oe", oe, 13'h1FFF);
        check("R9 full result", d, exp_res(4'd6, seq));

        // R10 narrow reads
        bus_wr(cfgv(4'd6, 0, 0, 0, 0));
        r = exp_res(4'd6, seq);
        bus_rd(d, oe);
        check("R5 narrow oe", oe, 13'h00FF);
        check("R10 low byte", d[7:0], r[7:0]);
        bus_rd(d, oe);
        check("R10 high byte", d[7:0], {3'b000, r[12:8]});
        cs_idle();
        bus_rd(d, oe); cs_idle();
        check("R10 pointer reset by CS", d[7:0], r[7:0]);

        // R7 R12 SYNC input mode, extra starts during busy
        bus_wr(cfgv(4'd9, 1, 1, 0, 0));
        check("R7 sync_oe input mode", sync_oe, 0);
        rdy_bad = 0;
        fork
            measure_busy(n);
            begin
                sync_i = 1'b1; repeat (4) @(negedge clk); sync_i = 1'b0;
                repeat (6) @(negedge clk);
                sync_i = 1'b1; repeat (4) @(negedge clk); sync_i = 1'b0;
                bus_wr(cfgv(4'd9, 1, 1, 0, 1));
            end
        join
        seq++;
        check("R12 busy length unchanged", n, CONV);
        check("R11 rdy_n during SYNC conversion", rdy_bad, 0);
        repeat (100) @(negedge clk);
        check("R12 no second conversion", rdy_n, 0);
        bus_rd(d, oe); cs_idle();
        check("R12 R9 single count added", d, exp_res(4'd9, seq));

        // R13 standby blocks starts
        bus_wr(cfgv(4'd9, 1, 0, 1, 0));
        check("R13 stdby_n low", stdby_n, 0);
        bus_wr(cfgv(4'd9, 1, 0, 1, 1));
        repeat (60) @(negedge clk);
        check("R13 no conversion in standby", {sync_o, rdy_n}, 2'b00);
        bus_wr(cfgv(4'd9, 1, 0, 0, 0));
        check("R13 stdby_n high", stdby_n, 1);
        bus_rd(d, oe); cs_idle();
        check("R13 result unchanged", d, exp_res(4'd9, seq));

        // Random conversions and reads: R6 R8 R9 R10
        for (int i = 0; i < 20; i++) begin
            logic [3:0] ch;
            logic bw;
            ch = 4'($urandom % 16);
            bw = 1'($urandom % 2);
            bus_wr(cfgv(ch, bw, 0, 0, 1));
            check("R6 random channel", mux_sel, ch);
            wait_ready();
            seq++;
            r = exp_res(ch, seq);
            if (bw) begin
                bus_rd(d, oe);
                check("R9 random full read", d, r);
            end else begin
                bus_rd(d, oe);
                check("R10 random low byte", d[7:0], r[7:0]);
                bus_rd(d, oe);
                check("R10 random high byte", d[7:0], {3'b000, r[12:8]});
            end
            cs_idle();
        end

        // R2 falling-edge mode after a reset with the strap high
        do_reset(1'b1);
        check("R1 mux_sel after second reset", mux_sel, 0);
        data_i = cfgv(4'd5, 1, 0, 0, 0); cs_n = 1'b0; wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 falling mode commit while WR low", mux_sel, 5);
        wr_n = 1'b1; repeat (4) @(negedge clk);
        cs_n = 1'b1; repeat (4) @(negedge clk);

        done = 1;
        finish_run();
    end
endmodule